// File: doc/BRIEF.md
# Cascadable DMA Channel Priority Arbiter

This block decides which of several DMA channels gets the system bus. Each channel has a hardware request line, a mask bit and a software request bit. When any request is live, the arbiter raises a hold request toward the bus master. Once the master answers with hold acknowledge, the arbiter grants the live request with the lowest channel index by driving that channel's acknowledge line. It holds the grant until that channel's request goes away or the service ends with an end-of-process event. Priority is fixed: channel 0 wins over all the others and the highest-numbered channel loses to every other.

Any channel can be marked as a cascade channel. Its request input then carries the hold request of a downstream controller, and its acknowledge output drives that controller's hold acknowledge input. For such a channel the arbiter only resolves priority. While the cascade grant is active it keeps the hold request up and drives the acknowledge line. It keeps its own address/strobe output enable and its end-of-process output low, and it ignores end-of-process inputs, so the downstream controller owns the bus. The acknowledge polarity is selectable. From reset the acknowledge lines are active low, so they sit high.

Top module: `dma_arb_top`

## Requirements
- R1: While reset is applied and after it is released with no requests, hrq is 0, ctrlOutEn and eopOut are 0, and with dackHighSel=0 every bit of dackOut is 1 (no channel acknowledged).
- R2: A hardware request on an unmasked channel, driven before a rising edge, raises hrq after the second rising edge. With no live request and no grant, hrq is 0.
- R3: If hlda is 1 while hrq is up and no channel is granted, the next rising edge grants the live request with the lowest channel index (bit i of dreq, swReqSet and dackOut belong to channel i). At most one acknowledge is ever active.
- R4: A granted channel keeps its acknowledge while its request stays live, even when a request with a lower index arrives. After the served request drops, the acknowledge clears on the second rising edge. hrq is then 0 for one cycle before arbitration restarts.
- R5: A mask bit of 1 blocks that channel's hardware request, both for normal and for cascade channels. A masked request alone never raises hrq, and a masked channel is skipped in favour of a live higher-index channel.
- R6: A one-cycle pulse on swReqSet[i] sets a stored software request for channel i. The mask bit does not block it. An end-of-process that ends channel i's service clears it.
- R7: While a cascade channel (cascadeEn[i]=1) is granted, dackOut shows that channel as acknowledged and hrq stays 1, while ctrlOutEn and eopOut stay 0 even if tcIn is 1.
- R8: While a cascade channel is granted, eopExt and tcIn have no effect: the grant remains until its request drops.
- R9: While a normal channel is granted, ctrlOutEn is 1 and eopOut follows tcIn. A 1 on eopExt or tcIn ends the grant at the next rising edge, and that channel is not granted again until its hardware request has been seen low.
- R10: With dackHighSel=1 the acknowledge lines are active high: dackOut is all 0 when idle and has only the granted channel's bit at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| dreq | input | NUM_CH | Hardware request per channel, active high |
| swReqSet | input | NUM_CH | Pulse that sets the stored software request of a channel |
| maskBits | input | NUM_CH | Per-channel mask; 1 blocks the hardware request |
| cascadeEn | input | NUM_CH | Per-channel cascade selection; 1 makes the channel arbitration-only |
| dackHighSel | input | 1 | Acknowledge polarity; 0 active low, 1 active high |
| hlda | input | 1 | Hold acknowledge from the bus master |
| eopExt | input | 1 | External end-of-process, active high |
| tcIn | input | 1 | Terminal count from the transfer datapath, active high |
| hrq | output | 1 | Hold request toward the bus master |
| dackOut | output | NUM_CH | Per-channel acknowledge, polarity set by dackHighSel |
| ctrlOutEn | output | 1 | Enable for the local address and strobe drivers |
| eopOut | output | 1 | End-of-process output, active high |

## Verification
The bench builds the arbiter with its default of four channels. This makes the lowest-priority channel, index 3, reachable from a software request behind a full mask, and lets ties between channels 1 and 3, and between 0 and 2, be resolved. With four channels one cascade channel and one normal channel can also be served one after the other in a single run, so the output gating of each kind of grant can be compared with the other. Index 3 is the largest value the two-bit grant register holds, so the top end of the channel decode is covered as well.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_SERVE = 2'd2
  } arbState_t;

  typedef struct packed {
    logic loadGrant;
    logic endService;
    logic eopHit;
  } arbStrobe_t;

endpackage

// File: rtl/dma_arb_dp.sv
module dma_arb_dp
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] dreq,
  input  logic [NUM_CH-1:0] swReqSet,
  input  logic [NUM_CH-1:0] maskBits,
  input  logic [NUM_CH-1:0] cascadeEn,
  input  logic              dackHighSel,
  input  arbStrobe_t        strobes,
  input  logic              dackEn,
  output logic              anyReq,
  output logic              grantLive,
  output logic              grantCascade,
  output logic [NUM_CH-1:0] dackOut
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] dreqQ;
  logic [NUM_CH-1:0] swReqQ;
  logic [NUM_CH-1:0] blockedQ;
  logic [NUM_CH-1:0] liveReq;
  logic [NUM_CH-1:0] arbReq;
  logic [NUM_CH-1:0] dackInt;
  logic [IDX_W-1:0]  winner;
  logic [IDX_W-1:0]  grantCh;

  // Hardware requests are registered once before use.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dreqQ <= '0;
    else       dreqQ <= dreq;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gCh
      logic isGrant;
      assign isGrant = (grantCh == IDX_W'(g));

      // Software request: set by pulse, cleared by an EOP that ends this channel.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          swReqQ[g] <= 1'b0;
        else if (strobes.eopHit && isGrant)
          swReqQ[g] <= 1'b0;
        else if (swReqSet[g])
          swReqQ[g] <= 1'b1;
      end

      // After an EOP the channel sits out until its hardware request is seen low.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          blockedQ[g] <= 1'b0;
        else if (strobes.eopHit && isGrant)
          blockedQ[g] <= 1'b1;
        else if (!dreqQ[g])
          blockedQ[g] <= 1'b0;
      end

      assign liveReq[g] = (dreqQ[g] & ~maskBits[g]) | swReqQ[g];
      assign arbReq[g]  = liveReq[g] & ~blockedQ[g];
      assign dackInt[g] = dackEn & isGrant;
    end
  endgenerate

  // Fixed priority: lowest index wins.
  always_comb begin
    winner = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (arbReq[i]) winner = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  grantCh <= '0;
    else if (strobes.loadGrant) grantCh <= winner;
  end

  assign anyReq       = |arbReq;
  assign grantLive    = liveReq[grantCh];
  assign grantCascade = cascadeEn[grantCh];
  assign dackOut      = dackHighSel ? dackInt : ~dackInt;

  AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dackInt)); // R3

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (dackEn && $past(dackEn)) |-> $stable(dackInt)); // R4

  AST_LOAD_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadGrant |=> arbReq[grantCh] || liveReq[grantCh] || !dackEn); // R3

endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       hlda,
  input  logic       grantLive,
  input  logic       grantCascade,
  input  logic       eopExt,
  input  logic       tcIn,
  output arbStrobe_t strobes,
  output logic       hrq,
  output logic       dackEn,
  output logic       ctrlOutEn,
  output logic       eopOut
);

  arbState_t state;
  arbState_t stateNext;

  always_comb begin
    strobes            = '0;
    strobes.loadGrant  = (state == ST_REQ) && hlda && anyReq;
    strobes.eopHit     = (state == ST_SERVE) && !grantCascade && (eopExt || tcIn);
    strobes.endService = (state == ST_SERVE) && (!grantLive || strobes.eopHit);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (anyReq) stateNext = ST_REQ;
      ST_REQ: begin
        if (!anyReq)                stateNext = ST_IDLE;
        else if (strobes.loadGrant) stateNext = ST_SERVE;
      end
      ST_SERVE: if (strobes.endService) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign hrq       = (state != ST_IDLE);
  assign dackEn    = (state == ST_SERVE);
  assign ctrlOutEn = dackEn && !grantCascade;
  assign eopOut    = ctrlOutEn && tcIn;

  AST_GRANT_AFTER_HLDA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dackEn) |-> $past(hlda)); // R3

  AST_CASCADE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (dackEn && grantCascade) |-> (!ctrlOutEn && !eopOut && hrq)); // R7

  AST_CASCADE_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (dackEn && grantCascade && grantLive) |=> dackEn); // R8

  AST_EOP_ENDS_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (dackEn && !grantCascade && (eopExt || tcIn)) |=> !dackEn); // R9

endmodule

// File: rtl/dma_arb_top.sv
module dma_arb_top
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] dreq,
  input  logic [NUM_CH-1:0] swReqSet,
  input  logic [NUM_CH-1:0] maskBits,
  input  logic [NUM_CH-1:0] cascadeEn,
  input  logic              dackHighSel,
  input  logic              hlda,
  input  logic              eopExt,
  input  logic              tcIn,
  output logic              hrq,
  output logic [NUM_CH-1:0] dackOut,
  output logic              ctrlOutEn,
  output logic              eopOut
);

  arbStrobe_t strobes;
  logic       anyReq;
  logic       grantLive;
  logic       grantCascade;
  logic       dackEn;

  dma_arb_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .anyReq       (anyReq),
    .hlda         (hlda),
    .grantLive    (grantLive),
    .grantCascade (grantCascade),
    .eopExt       (eopExt),
    .tcIn         (tcIn),
    .strobes      (strobes),
    .hrq          (hrq),
    .dackEn       (dackEn),
    .ctrlOutEn    (ctrlOutEn),
    .eopOut       (eopOut)
  );

  dma_arb_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .dreq         (dreq),
    .swReqSet     (swReqSet),
    .maskBits     (maskBits),
    .cascadeEn    (cascadeEn),
    .dackHighSel  (dackHighSel),
    .strobes      (strobes),
    .dackEn       (dackEn),
    .anyReq       (anyReq),
    .grantLive    (grantLive),
    .grantCascade (grantCascade),
    .dackOut      (dackOut)
  );

endmodule

// File: tb/dma_arb_top_bench.sv
`timescale 1ns/1ps
module dma_arb_top_bench;

  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] dreq = '0;
  logic [NCH-1:0] swReqSet = '0;
  logic [NCH-1:0] maskBits = '0;
  logic [NCH-1:0] cascadeEn = '0;
  logic           dackHighSel = 1'b0;
  logic           hlda = 1'b0;
  logic           eopExt = 1'b0;
  logic           tcIn = 1'b0;
  logic           hrq;
  logic [NCH-1:0] dackOut;
  logic           ctrlOutEn;
  logic           eopOut;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_arb_top #(.NUM_CH(NCH)) u_dma_arb_top (
    .clk(clk), .rstN(rstN), .dreq(dreq), .swReqSet(swReqSet),
    .maskBits(maskBits), .cascadeEn(cascadeEn), .dackHighSel(dackHighSel),
    .hlda(hlda), .eopExt(eopExt), .tcIn(tcIn), .hrq(hrq),
    .dackOut(dackOut), .ctrlOutEn(ctrlOutEn), .eopOut(eopOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [NCH-1:0] ackLow(input int ch);
    return ~(NCH'(1) << ch);
  endfunction

  task automatic waitHrq();
    for (int k = 0; k < 8; k++) begin
      if (hrq) break;
      tick(1);
    end
  endtask

  task automatic grantNow();
    waitHrq();
    hlda = 1'b1;
    tick(1);
  endtask

  task automatic settle();
    dreq = '0; swReqSet = '0; hlda = 1'b0; eopExt = 1'b0; tcIn = 1'b0;
    maskBits = '0; cascadeEn = '0;
    tick(5);
  endtask

  task automatic t_reset();
    chk("R1 hrq in reset", hrq, 0);
    chk("R1 dack in reset", dackOut, 4'hF);
    rstN = 1'b1;
    tick(2);
    chk("R1 hrq idle", hrq, 0);
    chk("R1 dack idle", dackOut, 4'hF);
    chk("R1 ctrlOutEn idle", ctrlOutEn, 0);
    chk("R1 eopOut idle", eopOut, 0);
  endtask

  task automatic t_basic();
    dreq = 4'b0100;
    tick(1);
    chk("R2 hrq after one edge", hrq, 0);
    tick(1);
    chk("R2 hrq after two edges", hrq, 1);
    chk("R3 no dack before hlda", dackOut, 4'hF);
    hlda = 1'b1;
    tick(1);
    chk("R3 grant ch2", dackOut, ackLow(2));
    chk("R9 ctrlOutEn normal", ctrlOutEn, 1);
    settle();
    chk("R2 hrq low after drop", hrq, 0);
  endtask

  task automatic t_priority();
    dreq = 4'b1010;
    grantNow();
    chk("R3 ch1 beats ch3", dackOut, ackLow(1));
    settle();
  endtask

  task automatic t_hold();
    dreq = 4'b0100;
    grantNow();
    chk("R4 grant ch2", dackOut, ackLow(2));
    dreq = 4'b0101;
    tick(3);
    chk("R4 ch2 held against ch0", dackOut, ackLow(2));
    dreq = 4'b0001;
    tick(1);
    chk("R4 still held one edge after drop", dackOut, ackLow(2));
    tick(1);
    chk("R4 released", dackOut, 4'hF);
    chk("R4 hrq gap", hrq, 0);
    tick(2);
    chk("R4 ch0 granted next", dackOut, ackLow(0));
    settle();
  endtask

  task automatic t_mask();
    maskBits = 4'b0001;
    dreq = 4'b0001;
    tick(4);
    chk("R5 masked no hrq", hrq, 0);
    dreq = 4'b1001;
    grantNow();
    chk("R5 masked ch0 skipped", dackOut, ackLow(3));
    settle();
    maskBits = 4'b0010; cascadeEn = 4'b0010;
    dreq = 4'b0010;
    tick(4);
    chk("R5 masked cascade no hrq", hrq, 0);
    settle();
  endtask

  task automatic t_swreq();
    maskBits = 4'b1111;
    swReqSet = 4'b1000;
    tick(1);
    swReqSet = '0;
    grantNow();
    chk("R6 sw request ch3 despite mask", dackOut, ackLow(3));
    eopExt = 1'b1;
    tick(1);
    eopExt = 1'b0;
    chk("R6 eop ends sw service", dackOut, 4'hF);
    tick(3);
    chk("R6 sw request cleared", hrq, 0);
    settle();
  endtask

  task automatic t_cascade();
    cascadeEn = 4'b0010;
    dreq = 4'b0010;
    grantNow();
    chk("R7 cascade dack", dackOut, ackLow(1));
    chk("R7 cascade hrq", hrq, 1);
    chk("R7 cascade ctrlOutEn", ctrlOutEn, 0);
    tcIn = 1'b1;
    #1;
    chk("R7 cascade eopOut", eopOut, 0);
    eopExt = 1'b1;
    tick(2);
    chk("R8 cascade ignores eop", dackOut, ackLow(1));
    eopExt = 1'b0; tcIn = 1'b0;
    dreq = 4'b0000;
    tick(2);
    chk("R8 cascade ends on drop", dackOut, 4'hF);
    settle();
  endtask

  task automatic t_eop();
    dreq = 4'b0100;
    grantNow();
    tcIn = 1'b1;
    #1;
    chk("R9 eopOut follows tc", eopOut, 1);
    tick(1);
    tcIn = 1'b0;
    chk("R9 tc ends grant", dackOut, 4'hF);
    tick(3);
    chk("R9 blocked until drop", hrq, 0);
    chk("R9 no regrant", dackOut, 4'hF);
    dreq = 4'b0000;
    tick(2);
    dreq = 4'b0100;
    tick(2);
    chk("R9 request again after drop", hrq, 1);
    tick(1);
    chk("R9 regrant after drop", dackOut, ackLow(2));
    settle();
  endtask

  task automatic t_polarity();
    dackHighSel = 1'b1;
    #1;
    chk("R10 idle high polarity", dackOut, 4'h0);
    dreq = 4'b0001;
    grantNow();
    chk("R10 active high grant", dackOut, 4'b0001);
    settle();
    dackHighSel = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_basic();
    t_priority();
    t_hold();
    t_mask();
    t_swreq();
    t_cascade();
    t_eop();
    t_polarity();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule